// File: doc/BRIEF.md
# Debug Command Response Sequencer

This block is the command engine behind a background-debug link that moves one 16-bit word in each direction per transfer. Every transfer carries a command word into the block and, in the same cycle, a 17-bit response word out of it (one status bit, then 16 data bits). The response a transfer returns depends only on what earlier transfers did, so replies run one transfer behind the commands that cause them.

The only command it runs is the register read. It picks one of eight data or eight address registers from a register file stub, waits a parameterised access latency, and returns the 32-bit value as two words, upper half first. The word that arrives with the lower half is taken as the next command, so reads can run back to back. Status codes carried in the response word report transfers that arrive during an access, unknown opcodes, reads issued while the core runs, and accesses that end in a bus error. The core's halt state and the bus-error signal are plain inputs.

Top module: `dbg_rsp_seq`

## Requirements
- R1: After reset, the first transfer returns status 0 with data 0x0000.
- R2: A word is a register read only when bits 15:12 = 0x2, bits 11:8 = 0x1 and bits 7:4 = 0x8. Bit 3 selects an address (1) or data (0) register and bits 2:0 give the register number. A read accepted while `core_halted` is 1 starts an access.
- R3: Transfers in the ACC_LAT cycles after the read command returns status 1 with data 0x0000 (not ready), and the words they carry are ignored.
- R4: The first transfer after the access returns status 0 with the upper 16 bits of the register. Its word is ignored. The next transfer returns status 0 with the lower 16 bits.
- R5: The word carried by the lower-half transfer, and by any illegal, bus-error or post-reset transfer, is decoded as the next command. This lets commands run with no idle transfers between them.
- R6: A read accepted while `core_halted` is 0 does no access. The next transfer returns status 1 with data 0x0001.
- R7: If `bus_err` is 1 in the cycle the access completes (the last not-ready cycle), the next transfer returns status 1 with data 0x0001 in place of both result words.
- R8: Any word that is not a register read does nothing, and the next transfer returns status 1 with data 0xFFFF.
- R9: Register k = {bit 3, bits 2:0} holds RF_SEED ^ (k * 0x10010011), truncated to 32 bits.
- R10: Without `xfer_valid` the sequencer does not advance, except that a pending access still completes. A finished result waits for any number of idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_valid | input | 1 | A word transfer takes place this cycle |
| xfer_word | input | 16 | Command word received by this transfer |
| core_halted | input | 1 | The core is halted; sampled with a read command |
| bus_err | input | 1 | The access ends in a bus error; sampled at completion |
| rsp_word | output | 17 | Response for this transfer: bit 16 status, bits 15:0 data |

## Verification
A transfer's response is read combinationally in the same cycle as its word, so the bench samples `rsp_word` one nanosecond after driving each word at the falling edge. After a read command accepted at cycle t, cycles t+1 to t+ACC_LAT are not ready and cycle t+ACC_LAT+1 holds the upper half. The bench therefore sends exactly ACC_LAT transfers before expecting the result. `bus_err` is held across those transfers so that it is present in the completion cycle. Idle gaps are inserted at several points to show that the result waits.

// File: rtl/dbg_rsp_pkg.sv
`timescale 1ns/1ps
package dbg_rsp_pkg;
   localparam int WORD_W = 16;
   localparam int RSP_W  = WORD_W + 1;
   localparam int REG_W  = 32;
   localparam int IDX_W  = 4;

   localparam logic [3:0] OPC_GRP  = 4'h2;
   localparam logic [3:0] OPC_SUB  = 4'h1;
   localparam logic [3:0] OPC_KIND = 4'h8;

   localparam logic [WORD_W-1:0] DATA_NOTRDY  = 16'h0000;
   localparam logic [WORD_W-1:0] DATA_ILLEGAL = 16'hFFFF;
   localparam logic [WORD_W-1:0] DATA_BUSERR  = 16'h0001;
   localparam logic [WORD_W-1:0] DATA_IDLE    = 16'h0000;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_BUSY,
      ST_UPPER,
      ST_LOWER,
      ST_ILL,
      ST_BERR
   } seq_state_e;

   typedef struct packed {
      logic             is_read;
      logic [IDX_W-1:0] idx;
   } cmd_dec_t;

   function automatic logic [RSP_W-1:0] mk_rsp(input logic st, input logic [WORD_W-1:0] d);
      return {st, d};
   endfunction
endpackage

// File: rtl/dbg_cmd_decode.sv
`timescale 1ns/1ps
module dbg_cmd_decode
   import dbg_rsp_pkg::*;
(
   input  logic [WORD_W-1:0] word,
   output cmd_dec_t          dec
);
   logic grp_ok, sub_ok, kind_ok;

   always_comb begin
      grp_ok      = (word[15:12] == OPC_GRP);
      sub_ok      = (word[11:8]  == OPC_SUB);
      kind_ok     = (word[7:4]   == OPC_KIND);
      dec.is_read = grp_ok & sub_ok & kind_ok;
      dec.idx     = word[3:0];
   end
endmodule

// File: rtl/dbg_access_timer.sv
`timescale 1ns/1ps
module dbg_access_timer #(
   parameter int ACC_LAT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic done
);
   localparam int CNT_W = $clog2(ACC_LAT + 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= CNT_W'(ACC_LAT);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/dbg_regfile_stub.sv
`timescale 1ns/1ps
module dbg_regfile_stub
   import dbg_rsp_pkg::*;
#(
   parameter logic [REG_W-1:0] RF_SEED = 32'hC0DE_5A00
) (
   input  logic [IDX_W-1:0] rd_idx,
   output logic [REG_W-1:0] rd_data
);
   localparam int NREG = 1 << IDX_W;
   localparam logic [REG_W-1:0] STEP = 32'h1001_0011;

   logic [REG_W-1:0] regs [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      assign regs[g] = RF_SEED ^ (REG_W'(g) * STEP);
   end

   assign rd_data = regs[rd_idx];
endmodule

// File: rtl/dbg_rsp_seq.sv
`timescale 1ns/1ps
module dbg_rsp_seq
   import dbg_rsp_pkg::*;
#(
   parameter int               ACC_LAT = 4,
   parameter logic [31:0]      RF_SEED = 32'hC0DE_5A00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_valid,
   input  logic [15:0]       xfer_word,
   input  logic              core_halted,
   input  logic              bus_err,
   output logic [16:0]       rsp_word
);
   if (ACC_LAT < 1) begin : g_lat_lo
      $error("ACC_LAT must be at least 1");
   end
   if (ACC_LAT > 65535) begin : g_lat_hi
      $error("ACC_LAT must not exceed 65535");
   end

   seq_state_e        state_q, state_d;
   cmd_dec_t          dec;
   logic              cmd_is_read;
   logic              accepting;
   logic              acc_start;
   logic              acc_done;
   logic [IDX_W-1:0]  idx_q;
   logic [REG_W-1:0]  rf_data;
   logic [REG_W-1:0]  res_q;

   dbg_cmd_decode u_dec (
      .word (xfer_word),
      .dec  (dec)
   );
   assign cmd_is_read = dec.is_read;

   dbg_access_timer #(.ACC_LAT(ACC_LAT)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (acc_start),
      .done  (acc_done)
   );

   dbg_regfile_stub #(.RF_SEED(RF_SEED)) u_rf (
      .rd_idx  (idx_q),
      .rd_data (rf_data)
   );

   always_comb begin
      accepting = 1'b0;
      case (state_q)
         ST_IDLE, ST_LOWER, ST_ILL, ST_BERR: accepting = xfer_valid;
         default:                            accepting = 1'b0;
      endcase
   end

   assign acc_start = accepting & dec.is_read & core_halted;

   always_comb begin
      state_d = state_q;
      if (accepting) begin
         if (!dec.is_read)      state_d = ST_ILL;
         else if (core_halted)  state_d = ST_BUSY;
         else                   state_d = ST_BERR;
      end else begin
         case (state_q)
            ST_BUSY:  if (acc_done)  state_d = bus_err ? ST_BERR : ST_UPPER;
            ST_UPPER: if (xfer_valid) state_d = ST_LOWER;
            default:  state_d = state_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         res_q   <= '0;
      end else begin
         state_q <= state_d;
         if (acc_start) idx_q <= dec.idx;
         if (state_q == ST_BUSY && acc_done && !bus_err) res_q <= rf_data;
      end
   end

   always_comb begin
      case (state_q)
         ST_BUSY:  rsp_word = mk_rsp(1'b1, DATA_NOTRDY);
         ST_UPPER: rsp_word = mk_rsp(1'b0, res_q[31:16]);
         ST_LOWER: rsp_word = mk_rsp(1'b0, res_q[15:0]);
         ST_ILL:   rsp_word = mk_rsp(1'b1, DATA_ILLEGAL);
         ST_BERR:  rsp_word = mk_rsp(1'b1, DATA_BUSERR);
         default:  rsp_word = mk_rsp(1'b0, DATA_IDLE);
      endcase
   end
endmodule

// File: rtl/dbg_rsp_seq_chk.sv
`timescale 1ns/1ps
module dbg_rsp_seq_chk
   import dbg_rsp_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        xfer_valid,
   input logic        core_halted,
   input logic        bus_err,
   input logic [16:0] rsp_word,
   input seq_state_e  state,
   input logic        cmd_is_read,
   input logic        acc_done
);
   logic acc_ok;
   assign acc_ok = xfer_valid &&
      (state == ST_IDLE || state == ST_LOWER || state == ST_ILL || state == ST_BERR);

   a_r3_busy_notready: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_BUSY |-> rsp_word == 17'h10000);
   a_r8_illegal_word: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_ILL |-> rsp_word == 17'h1FFFF);
   a_r6_berr_word: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_BERR |-> rsp_word == 17'h10001);
   a_r4_result_status: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_UPPER || state == ST_LOWER) |-> !rsp_word[16]);
   a_r2_read_starts: assert property (@(posedge clk) disable iff (!rst_n)
      acc_ok && cmd_is_read && core_halted |=> state == ST_BUSY);
   a_r6_running_core: assert property (@(posedge clk) disable iff (!rst_n)
      acc_ok && cmd_is_read && !core_halted |=> state == ST_BERR);
   a_r8_illegal_next: assert property (@(posedge clk) disable iff (!rst_n)
      acc_ok && !cmd_is_read |=> state == ST_ILL);
   a_r4_upper_then_lower: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_UPPER && xfer_valid |=> state == ST_LOWER);
   a_r7_berr_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_BUSY && acc_done && bus_err |=> state == ST_BERR);
   a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_valid && state != ST_BUSY |=> $stable(state));
endmodule

bind dbg_rsp_seq dbg_rsp_seq_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .xfer_valid  (xfer_valid),
   .core_halted (core_halted),
   .bus_err     (bus_err),
   .rsp_word    (rsp_word),
   .state       (state_q),
   .cmd_is_read (cmd_is_read),
   .acc_done    (acc_done)
);

// File: tb/dbg_rsp_seq_tb.sv
`timescale 1ns/1ps
module dbg_rsp_seq_tb;
   localparam int          LAT  = 4;
   localparam logic [31:0] SEED = 32'hC0DE_5A00;
   localparam logic [16:0] W_NOTRDY = 17'h10000;
   localparam logic [16:0] W_ILL    = 17'h1FFFF;
   localparam logic [16:0] W_BERR   = 17'h10001;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xfer_valid = 1'b0;
   logic [15:0] xfer_word = 16'h0;
   logic        core_halted = 1'b1;
   logic        bus_err = 1'b0;
   logic [16:0] rsp_word;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dbg_rsp_seq #(.ACC_LAT(LAT), .RF_SEED(SEED)) u_dut (
      .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_word(xfer_word),
      .core_halted(core_halted), .bus_err(bus_err), .rsp_word(rsp_word)
   );

   function automatic logic [31:0] rf_val(input int k);
      return SEED ^ (32'(k) * 32'h1001_0011);
   endfunction

   function automatic logic [15:0] rd_cmd(input int k);
      return {12'h218, 4'(k)};
   endfunction

   task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %05h expected %05h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic [15:0] w, output logic [16:0] r);
      @(negedge clk);
      xfer_valid = 1'b1;
      xfer_word  = w;
      #1 r = rsp_word;
      @(posedge clk);
      #1 xfer_valid = 1'b0;
   endtask

   task automatic xchk(input string req, input logic [15:0] w, input logic [16:0] exp);
      logic [16:0] r;
      xfer(w, r);
      check(req, r, exp);
   endtask

   task automatic wait_busy(input string req);
      for (int i = 0; i < LAT; i++) xchk(req, 16'h218D, W_NOTRDY);
   endtask

   task automatic t_reset();
      xchk("R1 first word after reset", 16'h0000, 17'h00000);
      xchk("R8 unassigned opcode", 16'h4F00, W_ILL);
      xchk("R8 near-miss 0x2283", 16'h2283, W_ILL);
      xchk("R2 near-miss 0x2193 illegal", 16'h2193, W_ILL);
   endtask

   task automatic t_back_to_back();
      xchk("R8 before read", rd_cmd(3), W_ILL);
      wait_busy("R3 not ready D3");
      xchk("R4 upper D3", 16'h1234, {1'b0, rf_val(3)[31:16]});
      xchk("R4 lower D3, R5 next cmd A5", rd_cmd(13), {1'b0, rf_val(3)[15:0]});
      wait_busy("R3 not ready A5");
      xchk("R5 upper A5", 16'h0000, {1'b0, rf_val(13)[31:16]});
      xchk("R5 lower A5", 16'h3000, {1'b0, rf_val(13)[15:0]});
   endtask

   task automatic t_gaps();
      xchk("R8 illegal after lower", rd_cmd(15), W_ILL);
      repeat (LAT + 10) @(posedge clk);
      xchk("R10 upper A7 after gap", 16'hAAAA, {1'b0, rf_val(15)[31:16]});
      repeat (5) @(posedge clk);
      xchk("R10 lower A7 after gap", 16'h0FFF, {1'b0, rf_val(15)[15:0]});
      xchk("R8 illegal after gap", 16'h0000, W_ILL);
   endtask

   task automatic t_not_halted();
      core_halted = 1'b0;
      xchk("R8 prior illegal", rd_cmd(1), W_ILL);
      core_halted = 1'b1;
      xchk("R6 read while running", rd_cmd(2), W_BERR);
      wait_busy("R3 not ready D2");
      xchk("R5 upper D2 after berr word", 16'h0000, {1'b0, rf_val(2)[31:16]});
      xchk("R5 lower D2", 16'h5555, {1'b0, rf_val(2)[15:0]});
   endtask

   task automatic t_bus_error();
      xchk("R8 prior illegal", rd_cmd(4), W_ILL);
      bus_err = 1'b1;
      wait_busy("R3 not ready D4");
      bus_err = 1'b0;
      xchk("R7 bus error word", rd_cmd(5), W_BERR);
      wait_busy("R3 not ready D5");
      xchk("R7 upper D5 after error", 16'h0000, {1'b0, rf_val(5)[31:16]});
      xchk("R7 lower D5 after error", 16'hFFFF, {1'b0, rf_val(5)[15:0]});
   endtask

   task automatic t_all_regs();
      xchk("R8 prior illegal", rd_cmd(0), W_ILL);
      for (int k = 0; k < 16; k++) begin
         wait_busy("R3 not ready sweep");
         xchk("R9 upper sweep", 16'h0000, {1'b0, rf_val(k)[31:16]});
         xchk("R9 lower sweep", (k < 15) ? rd_cmd(k + 1) : 16'h0000, {1'b0, rf_val(k)[15:0]});
      end
      xchk("R8 after sweep", 16'h0000, W_ILL);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_back_to_back();
      t_gaps();
      t_not_halted();
      t_bus_error();
      t_all_regs();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule